// File: doc/BRIEF.md
# TCE DMA Address Translator

This block converts a device DMA address into a physical address for a single DMA window. The window is divided into pages of size 2^shift, where the shift is a run-time setting. Each page has one 64-bit entry in an on-chip table. The upper bits of an entry hold the physical page base. The two lowest bits hold the access right for the page, so a single table word gives both the destination and the permission.

A lookup takes an address relative to the window start and a write flag. After a valid/ready handshake, the block returns the following one cycle later:
- the page-aligned IO address,
- the translated page base,
- the in-page offset mask,
- the two-bit permission,
- a fault flag,
- the combined physical address.

Table contents arrive on a separate update port, driven by an update engine. That port takes bus addresses, and the block subtracts the configured bus offset from them. After every reset, a clear sequence writes zero to every entry, so all pages start out faulting. Both handshakes stay blocked until that sweep is complete.

Top module: `tce_xlat`

## Requirements
- R1: The low two bits of a table entry give the page permission, reported on `rsp_perm`. The encoding is 0 = no access, 1 = read only, 2 = write only, 3 = read and write. Bit 0 grants reads and bit 1 grants writes.
- R2: `rsp_fault` is high when a write request meets permission 0 or 1, or a read request meets permission 0 or 2. It is low otherwise.
- R3: The page index is `req_addr` shifted right by `cfg_page_shift`. A lookup hits only when `cfg_enable` is high and the index is below the effective entry count.
- R4: A missed lookup returns permission 0, a zero IO address, a zero base, an all-ones mask, fault high, and `rsp_phys` equal to the request address.
- R5: While `cfg_enable` is low, every lookup misses.
- R6: On a hit, the block returns the following values:
  - `rsp_iova` is the request address with its low shift bits cleared.
  - `rsp_base` is the entry with its low shift bits cleared.
  - `rsp_mask` is 2^shift − 1.
  - `rsp_phys` is the base OR-ed with the request address AND-ed with the mask.
- R7: Each accepted request produces exactly one `rsp_valid` pulse, in the cycle right after acceptance. Responses come back in request order, and back-to-back requests are allowed.
- R8: Reset starts a sweep that zeroes all DEPTH entries. `req_ready` and `upd_ready` are low during reset and for exactly DEPTH cycles after reset is released.
- R9: An update writes the entry at index (`upd_addr` − `cfg_bus_offset`) >> shift, with the subtraction wrapping. If the block is disabled, or the index is not below the effective count, nothing is written and `upd_err` goes high for one cycle, one cycle later. Addresses below the offset count as out of range.
- R10: A lookup and an update to the same entry in the same cycle return the entry's old contents. The new value is seen from the next lookup onward.
- R11: The effective entry count is `cfg_entry_count` capped at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the table clear |
| cfg_enable | input | 1 | Window enable |
| cfg_page_shift | input | 6 | log2 of page size |
| cfg_entry_count | input | $clog2(DEPTH)+1 | Number of valid entries |
| cfg_bus_offset | input | 48 | Bus address of window start (update port only) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_addr | input | 48 | Window-relative DMA address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_iova | output | 48 | Page-aligned IO address |
| rsp_base | output | 64 | Translated page base |
| rsp_mask | output | 64 | In-page offset mask |
| rsp_perm | output | 2 | Permission code |
| rsp_fault | output | 1 | Access not permitted |
| rsp_phys | output | 64 | Full translated address |
| upd_valid | input | 1 | Table update valid |
| upd_ready | output | 1 | Update can be accepted |
| upd_addr | input | 48 | Bus address selecting the entry |
| upd_entry | input | 64 | New entry value |
| upd_err | output | 1 | Previous update was out of range |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs do not change between a request's acceptance and its response.
- The page shift stays below 64, so a hit mask can never be all ones. This is what lets the miss check key on an all-ones mask.

The stimulus respects these limits in the following ways:
- It changes the configuration only on idle cycles with no request in flight.
- It keeps page shifts at 0, 12 and 16.
- It drives requests and updates only while the matching ready signal is high.

// File: rtl/tce_xlat_pkg.sv
package tce_xlat_pkg;

    localparam int TCE_ADDR_W  = 48;
    localparam int TCE_ENTRY_W = 64;
    localparam int TCE_SHIFT_W = 6;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } tce_perm_e;

    typedef struct packed {
        logic [TCE_ADDR_W-1:0]  iova;
        logic [TCE_ENTRY_W-1:0] base;
        logic [TCE_ENTRY_W-1:0] mask;
        tce_perm_e              perm;
        logic                   fault;
        logic [TCE_ENTRY_W-1:0] phys;
    } tce_rsp_t;

    function automatic logic [TCE_ENTRY_W-1:0] page_mask(input logic [TCE_SHIFT_W-1:0] sh);
        return (TCE_ENTRY_W'(1) << sh) - TCE_ENTRY_W'(1);
    endfunction

    function automatic logic perm_denied(input tce_perm_e p, input logic wr);
        logic [1:0] bits;
        bits = p;
        return wr ? ~bits[1] : ~bits[0];
    endfunction

    function automatic logic [TCE_ADDR_W-1:0] cap_count(input logic [TCE_ADDR_W-1:0] cnt,
                                                        input int depth);
        return (cnt > TCE_ADDR_W'(depth)) ? TCE_ADDR_W'(depth) : cnt;
    endfunction

endpackage

// File: rtl/tce_clear_seq.sv
module tce_clear_seq #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             busy,
    output logic [IDX_W-1:0] clr_idx
);
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + IDX_W'(1);
            if (cnt == IDX_W'(DEPTH - 1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign clr_idx = cnt;

    // R8
    clear_start_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);

    // R8
    clear_done_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);

endmodule

// File: rtl/tce_entry_ram.sv
module tce_entry_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/tce_upd_port.sv
module tce_upd_port
    import tce_xlat_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   blocked,
    input  logic                   cfg_enable,
    input  logic [TCE_SHIFT_W-1:0] cfg_page_shift,
    input  logic [CNT_W-1:0]       cfg_entry_count,
    input  logic [TCE_ADDR_W-1:0]  cfg_bus_offset,
    input  logic                   upd_valid,
    input  logic [TCE_ADDR_W-1:0]  upd_addr,
    input  logic [TCE_ENTRY_W-1:0] upd_entry,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [TCE_ENTRY_W-1:0] wr_data,
    output logic                   upd_err
);
    logic [TCE_ADDR_W-1:0] rel_addr;
    logic [TCE_ADDR_W-1:0] page_idx;
    logic                  in_range;
    logic                  take;

    always_comb begin
        rel_addr = upd_addr - cfg_bus_offset;
        page_idx = rel_addr >> cfg_page_shift;
        in_range = cfg_enable &&
                   (page_idx < cap_count(TCE_ADDR_W'(cfg_entry_count), DEPTH));
        take     = upd_valid && !blocked;
        wr_en    = take && in_range;
        wr_idx   = page_idx[IDX_W-1:0];
        wr_data  = upd_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_err <= 1'b0;
        end else begin
            upd_err <= take && !in_range;
        end
    end

    // R9
    upd_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        upd_err |-> $past(upd_valid) && !$past(wr_en));

endmodule

// File: rtl/tce_lookup.sv
module tce_lookup
    import tce_xlat_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_ready,
    input  logic [TCE_ADDR_W-1:0]  req_addr,
    input  logic                   req_write,
    input  logic                   cfg_enable,
    input  logic [TCE_SHIFT_W-1:0] cfg_page_shift,
    input  logic [CNT_W-1:0]       cfg_entry_count,
    output logic                   ram_re,
    output logic [IDX_W-1:0]       ram_raddr,
    input  logic [TCE_ENTRY_W-1:0] ram_rdata,
    output logic                   rsp_valid,
    output tce_rsp_t               rsp
);
    logic                   accept;
    logic [TCE_ADDR_W-1:0]  page_idx;
    logic                   hit;

    logic                   vld_q;
    logic                   hit_q;
    logic                   wr_q;
    logic [TCE_ADDR_W-1:0]  addr_q;
    logic [TCE_ENTRY_W-1:0] mask_q;

    always_comb begin
        accept    = req_valid && req_ready;
        page_idx  = req_addr >> cfg_page_shift;
        hit       = cfg_enable &&
                    (page_idx < cap_count(TCE_ADDR_W'(cfg_entry_count), DEPTH));
        ram_re    = accept && hit;
        ram_raddr = page_idx[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            hit_q  <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            vld_q <= accept;
            if (accept) begin
                hit_q  <= hit;
                wr_q   <= req_write;
                addr_q <= req_addr;
                mask_q <= page_mask(cfg_page_shift);
            end
        end
    end

    always_comb begin
        if (hit_q) begin
            rsp.iova = addr_q & ~mask_q[TCE_ADDR_W-1:0];
            rsp.base = ram_rdata & ~mask_q;
            rsp.mask = mask_q;
            rsp.perm = tce_perm_e'(ram_rdata[1:0]);
        end else begin
            rsp.iova = '0;
            rsp.base = '0;
            rsp.mask = '1;
            rsp.perm = PERM_NONE;
        end
        rsp.fault = perm_denied(rsp.perm, wr_q);
        rsp.phys  = rsp.base | (TCE_ENTRY_W'(addr_q) & rsp.mask);
    end

    assign rsp_valid = vld_q;

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R7
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid) && $past(req_ready));

    // R6
    iova_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp.iova & rsp.mask[TCE_ADDR_W-1:0]) == '0);

    // R4
    miss_result_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp.mask == '1) |-> (rsp.perm == PERM_NONE && rsp.base == '0 && rsp.fault));

    // R2
    rw_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp.perm == PERM_RW) |-> !rsp.fault);

endmodule

// File: rtl/tce_xlat.sv
module tce_xlat
    import tce_xlat_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_enable,
    input  logic [TCE_SHIFT_W-1:0] cfg_page_shift,
    input  logic [CNT_W-1:0]       cfg_entry_count,
    input  logic [TCE_ADDR_W-1:0]  cfg_bus_offset,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [TCE_ADDR_W-1:0]  req_addr,
    input  logic                   req_write,
    output logic                   rsp_valid,
    output logic [TCE_ADDR_W-1:0]  rsp_iova,
    output logic [TCE_ENTRY_W-1:0] rsp_base,
    output logic [TCE_ENTRY_W-1:0] rsp_mask,
    output logic [1:0]             rsp_perm,
    output logic                   rsp_fault,
    output logic [TCE_ENTRY_W-1:0] rsp_phys,
    input  logic                   upd_valid,
    output logic                   upd_ready,
    input  logic [TCE_ADDR_W-1:0]  upd_addr,
    input  logic [TCE_ENTRY_W-1:0] upd_entry,
    output logic                   upd_err
);
    logic                   clr_busy;
    logic [IDX_W-1:0]       clr_idx;

    logic                   up_we;
    logic [IDX_W-1:0]       up_idx;
    logic [TCE_ENTRY_W-1:0] up_data;

    logic                   ram_we;
    logic [IDX_W-1:0]       ram_waddr;
    logic [TCE_ENTRY_W-1:0] ram_wdata;
    logic                   ram_re;
    logic [IDX_W-1:0]       ram_raddr;
    logic [TCE_ENTRY_W-1:0] ram_rdata;

    tce_rsp_t               rsp;

    tce_clear_seq #(.DEPTH(DEPTH)) u_clear (
        .clk     (clk),
        .rst     (rst),
        .busy    (clr_busy),
        .clr_idx (clr_idx)
    );

    tce_upd_port #(.DEPTH(DEPTH)) u_upd (
        .clk             (clk),
        .rst             (rst),
        .blocked         (clr_busy),
        .cfg_enable      (cfg_enable),
        .cfg_page_shift  (cfg_page_shift),
        .cfg_entry_count (cfg_entry_count),
        .cfg_bus_offset  (cfg_bus_offset),
        .upd_valid       (upd_valid),
        .upd_addr        (upd_addr),
        .upd_entry       (upd_entry),
        .wr_en           (up_we),
        .wr_idx          (up_idx),
        .wr_data         (up_data),
        .upd_err         (upd_err)
    );

    always_comb begin
        if (clr_busy) begin
            ram_we    = 1'b1;
            ram_waddr = clr_idx;
            ram_wdata = '0;
        end else begin
            ram_we    = up_we;
            ram_waddr = up_idx;
            ram_wdata = up_data;
        end
    end

    tce_entry_ram #(.DEPTH(DEPTH), .WIDTH(TCE_ENTRY_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign req_ready = ~clr_busy;
    assign upd_ready = ~clr_busy;

    tce_lookup #(.DEPTH(DEPTH)) u_lookup (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_addr        (req_addr),
        .req_write       (req_write),
        .cfg_enable      (cfg_enable),
        .cfg_page_shift  (cfg_page_shift),
        .cfg_entry_count (cfg_entry_count),
        .ram_re          (ram_re),
        .ram_raddr       (ram_raddr),
        .ram_rdata       (ram_rdata),
        .rsp_valid       (rsp_valid),
        .rsp             (rsp)
    );

    assign rsp_iova  = rsp.iova;
    assign rsp_base  = rsp.base;
    assign rsp_mask  = rsp.mask;
    assign rsp_perm  = rsp.perm;
    assign rsp_fault = rsp.fault;
    assign rsp_phys  = rsp.phys;

    // R8
    clear_owns_ram_chk: assert property (@(posedge clk) disable iff (rst)
        clr_busy |-> !up_we);

endmodule

// File: tb/tb_tce_xlat.sv
`timescale 1ns/1ps
module tb_tce_xlat;
    localparam int DEPTH = 64;
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_en;
    logic [5:0]  cfg_sh;
    logic [CNT_W-1:0] cfg_cnt;
    logic [47:0] cfg_off;
    logic        req_valid, req_ready, req_write;
    logic [47:0] req_addr;
    logic        rsp_valid, rsp_fault;
    logic [47:0] rsp_iova;
    logic [63:0] rsp_base, rsp_mask, rsp_phys;
    logic [1:0]  rsp_perm;
    logic        upd_valid, upd_ready, upd_err;
    logic [47:0] upd_addr;
    logic [63:0] upd_entry;

    always #4 clk = ~clk;

    tce_xlat #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_en), .cfg_page_shift(cfg_sh),
        .cfg_entry_count(cfg_cnt), .cfg_bus_offset(cfg_off),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_base(rsp_base),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .rsp_phys(rsp_phys),
        .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_addr(upd_addr), .upd_entry(upd_entry), .upd_err(upd_err)
    );

    typedef struct {
        logic [47:0] iova;
        logic [63:0] base;
        logic [63:0] mask;
        logic [1:0]  perm;
        logic        fault;
        logic [63:0] phys;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [63:0] model [DEPTH];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int cap_now();
        return (int'(cfg_cnt) > DEPTH) ? DEPTH : int'(cfg_cnt);
    endfunction

    function automatic exp_t predict(input logic [47:0] a, input logic wr, input string tag);
        exp_t e;
        logic [47:0] idx;
        logic [63:0] m, ent;
        idx = a >> cfg_sh;
        e.tag = tag;
        if (cfg_en && idx < 48'(cap_now())) begin
            m = (64'd1 << cfg_sh) - 64'd1;
            ent = model[int'(idx)];
            e.iova = a & ~m[47:0];
            e.base = ent & ~m;
            e.mask = m;
            e.perm = ent[1:0];
            e.fault = wr ? (ent[1:0] == 2'd0 || ent[1:0] == 2'd1)
                         : (ent[1:0] == 2'd0 || ent[1:0] == 2'd2);
        end else begin
            e.iova = '0; e.base = '0; e.mask = '1; e.perm = 2'd0; e.fault = 1'b1;
        end
        e.phys = e.base | ({16'd0, a} & e.mask);
        return e;
    endfunction

    function automatic bit upd_target(input logic [47:0] a, output int idx);
        logic [47:0] rel;
        logic [47:0] pi;
        rel = a - cfg_off;
        pi = rel >> cfg_sh;
        idx = int'(pi[5:0]);
        return cfg_en && (pi < 48'(cap_now()));
    endfunction

    // monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk("R7", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "iova",  64'(rsp_iova), 64'(e.iova));
                chk(e.tag, "base",  rsp_base, e.base);
                chk(e.tag, "mask",  rsp_mask, e.mask);
                chk(e.tag, "perm",  64'(rsp_perm), 64'(e.perm));
                chk(e.tag, "fault", 64'(rsp_fault), 64'(e.fault));
                chk(e.tag, "phys",  rsp_phys, e.phys);
            end
        end
    end

    task automatic lookup(input logic [47:0] a, input logic wr, input string tag);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        sbq.push_back(predict(a, wr, tag));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic update(input logic [47:0] a, input logic [63:0] ent,
                          input logic exp_err, input string tag);
        int idx;
        bit ok;
        upd_valid = 1'b1; upd_addr = a; upd_entry = ent;
        ok = upd_target(a, idx);
        if (ok) model[idx] = ent;
        @(negedge clk);
        upd_valid = 1'b0;
        chk(tag, "upd_err", 64'(upd_err), 64'(exp_err));
    endtask

    task automatic do_reset();
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "req_ready in reset", 64'(req_ready), 64'd0);
        chk("R8", "upd_ready in reset", 64'(upd_ready), 64'd0);
        chk("R7", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 64'd0;
        n = 0;
        while (!req_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R8", "clear cycles", 64'(n), 64'(DEPTH));
        chk("R8", "upd_ready after clear", 64'(upd_ready), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [47:0] off;
        int junk;
        off = 48'h0000_1000_0000;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        upd_valid = 1'b0; upd_addr = '0; upd_entry = '0;
        cfg_en = 1'b1; cfg_sh = 6'd12; cfg_cnt = CNT_W'(DEPTH); cfg_off = off;
        @(negedge clk);
        do_reset();

        // R8 every entry zero after clear: hit with no permission
        lookup(48'h0000_0000, 1'b0, "R8");
        lookup(48'h0003_F123, 1'b1, "R8");

        cfg_cnt = CNT_W'(16);
        update(off + 48'h0123, 64'h0000_00AB_CDEF_1001, 1'b0, "R9");
        update(off + 48'h1FFF, 64'h0000_0012_3456_7002, 1'b0, "R9");
        update(off + 48'h2000, 64'hFFFF_0000_8888_9FF3, 1'b0, "R9");
        update(off + 48'h3400, 64'h0000_0000_7777_0000, 1'b0, "R9");
        update(off + 48'hF000, 64'h0000_0000_5555_5003, 1'b0, "R9");

        // R1 R2 permissions, read and write, back to back
        lookup(48'h0ABC, 1'b0, "R1");
        lookup(48'h0ABC, 1'b1, "R2");
        lookup(48'h1234, 1'b0, "R2");
        lookup(48'h1234, 1'b1, "R1");
        lookup(48'h2FFF, 1'b0, "R1");
        lookup(48'h2001, 1'b1, "R2");
        lookup(48'h3010, 1'b0, "R2");
        lookup(48'h3010, 1'b1, "R2");
        lookup(48'h4567, 1'b0, "R6");
        // R3 bound of the window
        lookup(48'hFFFF, 1'b0, "R3");
        lookup(48'h10000, 1'b0, "R4");
        lookup(48'hFFFF_FFFF_FFFF, 1'b1, "R4");
        @(negedge clk);

        // R9 rejected updates leave entries unchanged
        update(off + 48'h42000, 64'h0000_0000_DEAD_B003, 1'b1, "R9");
        update(off - 48'h1000, 64'h0000_0000_DEAD_C003, 1'b1, "R9");
        update(off + 48'h10000, 64'h0000_0000_DEAD_D003, 1'b1, "R9");
        lookup(48'h2000, 1'b0, "R9");
        lookup(48'hF000, 1'b0, "R9");
        lookup(48'h0000, 1'b0, "R9");
        @(negedge clk);

        // R5 disabled window
        cfg_en = 1'b0;
        lookup(48'h2000, 1'b0, "R5");
        update(off + 48'h2000, 64'h0000_0000_BAD0_0003, 1'b1, "R5");
        cfg_en = 1'b1;
        lookup(48'h2000, 1'b1, "R5");
        @(negedge clk);

        // R6 larger page shift
        cfg_sh = 6'd16; cfg_cnt = CNT_W'(4);
        lookup(48'h2_1234, 1'b0, "R6");
        lookup(48'h3_FFFF, 1'b1, "R6");
        lookup(48'h4_0000, 1'b0, "R3");
        update(off + 48'h1_0008, 64'h0000_0042_0001_0002, 1'b0, "R9");
        lookup(48'h1_ABCD, 1'b1, "R6");
        @(negedge clk);

        // R6 zero page shift
        cfg_sh = 6'd0; cfg_cnt = CNT_W'(16);
        lookup(48'h2, 1'b0, "R6");
        @(negedge clk);

        // R11 count above depth capped
        cfg_sh = 6'd12; cfg_cnt = CNT_W'(100);
        lookup(48'h3F000, 1'b0, "R11");
        lookup(48'h40000, 1'b0, "R11");
        update(off + 48'h40000, 64'h0000_0000_ABCD_0003, 1'b1, "R11");
        @(negedge clk);

        // R10 same-cycle lookup and update of one entry
        cfg_cnt = CNT_W'(16);
        req_valid = 1'b1; req_addr = 48'h1010; req_write = 1'b1;
        sbq.push_back(predict(48'h1010, 1'b1, "R10"));
        upd_valid = 1'b1; upd_addr = off + 48'h1000;
        upd_entry = 64'h0000_0099_0000_1003;
        void'(upd_target(off + 48'h1000, junk));
        model[junk] = 64'h0000_0099_0000_1003;
        @(negedge clk);
        req_valid = 1'b0; upd_valid = 1'b0;
        chk("R10", "upd_err", 64'(upd_err), 64'd0);
        lookup(48'h1010, 1'b1, "R10");
        @(negedge clk);

        // R8 second reset wipes written entries
        do_reset();
        lookup(48'h2000, 1'b0, "R8");
        lookup(48'hF000, 1'b1, "R8");
        @(negedge clk);
        @(negedge clk);

        chk("R7", "responses outstanding", 64'(sbq.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule